// File: doc/BRIEF.md
# Two-way mixed-width dot-accumulate unit

This block multiplies the two 16-bit lanes of one packed 32-bit operand by two of the four 8-bit lanes of a second packed 32-bit operand. It adds both products to a 32-bit accumulator input and returns a 32-bit sum. Each operand has its own signedness control, which selects sign or zero extension of its lanes. A half-select input picks either the low byte pair or the high byte pair of the byte operand.

The unit is meant for the integer pipes of a compute datapath. In the default configuration a request is accepted whenever `in_vld` is high, and the result is presented one cycle later, qualified by `out_vld`. A build parameter removes the output register, which makes the unit purely combinational.

Top module: `dp2_mac`

## Requirements
- R1: Lane packing is little-endian. Word-lane 0 is `opa[15:0]` and word-lane 1 is `opa[31:16]`. Byte lane i is `opb[8i+7:8i]`.
- R2: With `b_upper`=0, word-lane 0 pairs with byte 0 and word-lane 1 pairs with byte 1. With `b_upper`=1, word-lane 0 pairs with byte 2 and word-lane 1 pairs with byte 3.
- R3: `opa_sgn`=1 sign-extends the word lanes to 32 bits. `opa_sgn`=0 zero-extends them.
- R4: `opb_sgn`=1 sign-extends the selected byte lanes to 32 bits. `opb_sgn`=0 zero-extends them.
- R5: `res` equals the sum of the two products plus `acc`, taken modulo 2^32. There is no saturation and no overflow indication. Mode {opa_sgn,opb_sgn} means 00 = unsigned by unsigned, 01 = unsigned by signed, 10 = signed by unsigned, 11 = signed by signed.
- R6: With the output register present, `out_vld` and `res` appear exactly one clock after the cycle in which `in_vld` is high. `out_vld` is low one clock after a cycle with `in_vld` low.
- R7: With the output register present, `res` holds its value across cycles with `in_vld` low.
- R8: A synchronous active-high reset `rst` drives `out_vld` and `res` to 0.
- R9: The two byte lanes that the half-select does not choose have no effect on `res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Request valid |
| opa | input | 32 | Two packed 16-bit lanes |
| opb | input | 32 | Four packed 8-bit lanes |
| acc | input | 32 | Accumulator addend |
| opa_sgn | input | 1 | Word lanes are signed |
| opb_sgn | input | 1 | Byte lanes are signed |
| b_upper | input | 1 | Select byte pair 2/3 instead of 0/1 |
| out_vld | output | 1 | Result valid |
| res | output | 32 | Dot-accumulate result |

## Verification
The only internal state is the output register pair. If the valid flag is lost or duplicated, `out_vld` goes out of step with `in_vld` on the next clock. The scoreboard then sees either an empty queue or a result that never arrives. A wrong extension or a wrong byte choice shows in `res` on the first request that uses a negative or high-bit lane. For that reason the corner values 0x8000, 0x7FFF, 0x80 and 0xFF are driven in all four modes and both halves. A register that loads while idle shows as a changed `res` during idle cycles.

// File: rtl/dp2_pkg.sv
package dp2_pkg;
    localparam int WORD_W = 32;
    localparam int WIDE_W = 16;
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        MODE_UU = 2'b00,
        MODE_US = 2'b01,
        MODE_SU = 2'b10,
        MODE_SS = 2'b11
    } dp2_mode_e;
endpackage

// File: rtl/dp2_lane_ext.sv
module dp2_lane_ext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  lane,
    input  logic             sgn,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD_W = OUT_W - IN_W;

    always_comb begin
        ext = {{PAD_W{sgn & lane[IN_W-1]}}, lane};
    end
endmodule

// File: rtl/dp2_mul_term.sv
module dp2_mul_term #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] p
);
    // Low W bits of a product do not depend on the signed interpretation
    always_comb begin
        p = x * y;
    end
endmodule

// File: rtl/dp2_mac.sv
module dp2_mac
    import dp2_pkg::*;
#(
    parameter int ACC_W    = WORD_W,
    parameter int A_LANE_W = WIDE_W,
    parameter int B_LANE_W = NARROW_W,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ACC_W-1:0] opa,
    input  logic [ACC_W-1:0] opb,
    input  logic [ACC_W-1:0] acc,
    input  logic             opa_sgn,
    input  logic             opb_sgn,
    input  logic             b_upper,
    output logic             out_vld,
    output logic [ACC_W-1:0] res
);
    localparam int TERMS = ACC_W / A_LANE_W;

    dp2_mode_e mode;
    logic      a_ext_sgn;
    logic      b_ext_sgn;

    assign mode = dp2_mode_e'({opa_sgn, opb_sgn});

    always_comb begin
        unique case (mode)
            MODE_UU: begin a_ext_sgn = 1'b0; b_ext_sgn = 1'b0; end
            MODE_US: begin a_ext_sgn = 1'b0; b_ext_sgn = 1'b1; end
            MODE_SU: begin a_ext_sgn = 1'b1; b_ext_sgn = 1'b0; end
            MODE_SS: begin a_ext_sgn = 1'b1; b_ext_sgn = 1'b1; end
            default: begin a_ext_sgn = 1'b0; b_ext_sgn = 1'b0; end
        endcase
    end

    logic [ACC_W-1:0] prod [TERMS];

    for (genvar k = 0; k < TERMS; k++) begin : g_term
        logic [A_LANE_W-1:0] a_lane;
        logic [B_LANE_W-1:0] b_lane;
        logic [ACC_W-1:0]    a_wide;
        logic [ACC_W-1:0]    b_wide;

        assign a_lane = opa[k*A_LANE_W +: A_LANE_W];
        assign b_lane = b_upper ? opb[(TERMS+k)*B_LANE_W +: B_LANE_W]
                                : opb[k*B_LANE_W +: B_LANE_W];

        dp2_lane_ext #(.IN_W(A_LANE_W), .OUT_W(ACC_W)) u_ext_a (
            .lane (a_lane),
            .sgn  (a_ext_sgn),
            .ext  (a_wide)
        );

        dp2_lane_ext #(.IN_W(B_LANE_W), .OUT_W(ACC_W)) u_ext_b (
            .lane (b_lane),
            .sgn  (b_ext_sgn),
            .ext  (b_wide)
        );

        dp2_mul_term #(.W(ACC_W)) u_mul (
            .x (a_wide),
            .y (b_wide),
            .p (prod[k])
        );
    end

    logic [ACC_W-1:0] sum_d;

    always_comb begin
        sum_d = acc;
        for (int k = 0; k < TERMS; k++) begin
            sum_d = sum_d + prod[k];
        end
    end

    if (REG_OUT) begin : g_reg
        logic             vld_q;
        logic [ACC_W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                res_q <= '0;
            end else begin
                vld_q <= in_vld;
                if (in_vld) begin
                    res_q <= sum_d;
                end
            end
        end

        assign out_vld = vld_q;
        assign res     = res_q;
    end else begin : g_comb
        assign out_vld = in_vld;
        assign res     = sum_d;
    end
endmodule

// File: rtl/dp2_mac_chk.sv
module dp2_mac_chk #(
    parameter int ACC_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [ACC_W-1:0] opa,
    input logic [ACC_W-1:0] opb,
    input logic [ACC_W-1:0] acc,
    input logic             b_upper,
    input logic             out_vld,
    input logic [ACC_W-1:0] res
);
    localparam int HALF = ACC_W / 2;

    logic [HALF-1:0] sel_bytes;
    assign sel_bytes = b_upper ? opb[ACC_W-1:HALF] : opb[HALF-1:0];

    if (REG_OUT) begin : g_seq
        assert_vld_follow_R6: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> out_vld);
        assert_vld_drop_R6: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> !out_vld);
        assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> $stable(res));
        assert_reset_clear_R8: assert property (@(posedge clk)
            rst |=> (!out_vld && res == '0));
        assert_zero_a_R5: assert property (@(posedge clk) disable iff (rst)
            (in_vld && opa == '0) |=> res == $past(acc));
        assert_zero_sel_R9: assert property (@(posedge clk) disable iff (rst)
            (in_vld && sel_bytes == '0) |=> res == $past(acc));
    end else begin : g_cmb
        always_comb begin
            if (!rst) begin
                assert_vld_pass_R6: assert (out_vld == in_vld);
            end
        end
    end
endmodule

bind dp2_mac dp2_mac_chk #(.ACC_W(ACC_W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .opa     (opa),
    .opb     (opb),
    .acc     (acc),
    .b_upper (b_upper),
    .out_vld (out_vld),
    .res     (res)
);

// File: tb/dp2_mac_tb.sv
module dp2_mac_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [31:0] opa, opb, acc;
    logic        opa_sgn, opb_sgn, b_upper;
    logic        out_vld;
    logic [31:0] res;

    always #5 clk = ~clk;

    dp2_mac u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb), .acc(acc),
        .opa_sgn(opa_sgn), .opb_sgn(opb_sgn), .b_upper(b_upper),
        .out_vld(out_vld), .res(res)
    );

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    logic done  = 1'b0;

    function automatic logic [31:0] ref_dp(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] c, input logic as,
                                           input logic bs, input logic hi);
        longint a0, a1, b0, b1, s;
        logic [7:0] bl, bh;
        bl = hi ? b[23:16] : b[7:0];
        bh = hi ? b[31:24] : b[15:8];
        a0 = as ? longint'($signed(a[15:0]))  : longint'({48'b0, a[15:0]});
        a1 = as ? longint'($signed(a[31:16])) : longint'({48'b0, a[31:16]});
        b0 = bs ? longint'($signed(bl)) : longint'({56'b0, bl});
        b1 = bs ? longint'($signed(bh)) : longint'({56'b0, bh});
        s  = a0 * b0 + a1 * b1 + longint'($signed(c));
        return s[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic as, input logic bs, input logic hi, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1; opa = a; opb = b; acc = c;
        opa_sgn = as; opb_sgn = bs; b_upper = hi;
        e.val = ref_dp(a, b, c, as, bs, hi);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            opa = 32'hDEAD_BEEF; opb = 32'h1234_5678; acc = 32'h0BAD_F00D;
        end
    endtask

    // Monitor: pops one expected item per valid result (R6 ordering)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected out_vld", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, res, e.val);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=hang exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [31:0] corner_a [6];
    logic [31:0] corner_b [6];
    logic [31:0] seed;
    logic [31:0] held;

    initial begin
        corner_a[0] = 32'h8000_8000; corner_b[0] = 32'h8080_8080;
        corner_a[1] = 32'h7FFF_7FFF; corner_b[1] = 32'hFFFF_FFFF;
        corner_a[2] = 32'h8000_7FFF; corner_b[2] = 32'h80FF_FF80;
        corner_a[3] = 32'hFFFF_0001; corner_b[3] = 32'h7F01_017F;
        corner_a[4] = 32'h0001_FFFF; corner_b[4] = 32'h0180_8001;
        corner_a[5] = 32'h1234_ABCD; corner_b[5] = 32'hC3A5_5A3C;

        rst = 1'b1; in_vld = 1'b0; opa = '0; opb = '0; acc = '0;
        opa_sgn = 1'b0; opb_sgn = 1'b0; b_upper = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset out_vld", {31'b0, out_vld}, 32'd0);
        check("R8 reset res", res, 32'd0);
        rst = 1'b0;

        // R1 R2: single nonzero lanes reveal packing and pairing
        send(32'h0000_0003, 32'h0000_0005, 32'd0, 1'b0, 1'b0, 1'b0, "R1 lane0 x byte0");
        send(32'h0007_0000, 32'h0000_0B00, 32'd0, 1'b0, 1'b0, 1'b0, "R1 lane1 x byte1");
        send(32'h0007_0003, 32'h0B05_0000, 32'd10, 1'b0, 1'b0, 1'b1, "R2 upper pair");
        // R9: unselected bytes changed, result must match
        send(32'h0002_0003, 32'hFFFF_0405, 32'd1, 1'b1, 1'b1, 1'b0, "R9 upper bytes ignored");
        send(32'h0002_0003, 32'h0405_AA55, 32'd1, 1'b1, 1'b1, 1'b1, "R9 lower bytes ignored");
        // R5 wrap
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R5 wrap");
        send(32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 1'b1, "R5 zero product");

        // R3 R4: all modes x halves x corners, back to back
        for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 2; h++) begin
                for (int v = 0; v < 6; v++) begin
                    send(corner_a[v], corner_b[v], 32'h7FFF_FFF0 + v,
                         m[1], m[0], h[0], "R3 R4 corner mode");
                end
            end
        end

        // R7: hold across idle cycles
        send(32'h8000_7FFF, 32'h80FF_80FF, 32'h0000_1000, 1'b1, 1'b0, 1'b1, "R6 before idle");
        idle(1);
        @(negedge clk);
        held = res;
        idle(4);
        check("R7 hold res", res, held);
        check("R6 out_vld low when idle", {31'b0, out_vld}, 32'd0);

        // pseudo-random mix with gaps
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra, rb, rc;
            seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; rb = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; rc = seed;
            send(ra, rb, rc, rc[3], rc[7], rc[11], "R5 random");
            if (rc[13]) idle(1);
        end
        idle(3);

        // R8: reset in mid-stream clears the output
        send(32'h0001_0001, 32'h0101_0101, 32'd5, 1'b0, 1'b0, 1'b0, "R6 before reset");
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        void'(exp_q.pop_front());
        @(negedge clk);
        check("R8 mid reset out_vld", {31'b0, out_vld}, 32'd0);
        check("R8 mid reset res", res, 32'd0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        if (exp_q.size() != 0) check("R6 results missing", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule